// File: doc/BRIEF.md
# Single-Channel DMA Word Mover

This block is one DMA channel that copies 32-bit words between a memory port and a peripheral port. Software sets it up through three registers: a start address, a block-size word and a control word. The control word picks the direction, whether the memory address counts up or down, and one of three ways to move data: a single burst, a series of slices that the peripheral paces with its request, or a walk through a linked list of packets held in memory. Writing the start bit begins a transfer. That bit then reads back as the busy flag until the last word has moved.

The memory port answers in the same cycle: read data belongs to the address presented in that cycle, and a write takes effect at the clock edge. The peripheral side has a write strobe with data for words going to the peripheral, a read strobe for words taken from it, and a request input. Each burst, each slice and each chain node waits for that request unless the control word says to bypass it. While a transfer is running, software keeps its hands off: every register write is dropped until completion.

Top module: `dma_channel`

## Requirements
- R1: After reset the address, block and control registers read 0 (register selects 0, 1 and 2), `done_o` is low and no port strobe is active.
- R2: With control bit 0 set, every moved word is read from memory at `mem_addr_o` and appears in the same cycle on `per_wdata_o` with `per_wr_o` high, and `mem_we_o` stays low.
- R3: With control bit 0 clear, every moved word is taken from `per_rdata_i` with `per_rd_o` high and written to memory at `mem_addr_o` with `mem_we_o` high.
- R4: The byte address ignores bits [1:0] of the written value. It moves by +4 per word, or by -4 when control bit 1 is set, and it reads back at register select 0 as the next address to be used.
- R5: With control bits 9 and 10 clear, a transfer moves block bits [15:0] words, one per cycle, with no gaps.
- R6: With control bit 9 set and bit 10 clear, the channel moves block bits [31:16] slices of block bits [15:0] words each. Every slice begins in its own request-gated wait cycle.
- R7: A burst, slice or chain node does not start while `per_req_i` is low, unless control bit 28 is set.
- R8: With control bit 10 set, each list node starts with a header word holding the payload count in bits [31:24] and the next node address in bits [23:0]. Its payload words follow upward from the header address plus 4 and always go to the peripheral; control bits 0 and 1 are ignored in this mode.
- R9: A header whose next address has bit 23 set ends the chain after that node's payload. A node with a count of 0 moves no words.
- R10: A control write with bit 24 set starts the channel. Bit 24 reads back as 1 from the next cycle until completion. `done_o` is high for exactly the one cycle in which bit 24 has just dropped.
- R11: While the channel is busy, writes to any register are ignored. This includes a second start.
- R12: A non-chain transfer with a zero word count, or a slice transfer with a zero slice count, stays busy for one cycle, moves nothing and then completes with a done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 address, 1 block, 2 control |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the selected register (combinational) |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | Memory write (else read) |
| mem_addr_o | output | ADDR_W | Memory byte address, word aligned |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data for the current address |
| per_req_i | input | 1 | Peripheral request |
| per_wr_o | output | 1 | Word presented to the peripheral |
| per_wdata_o | output | 32 | Data to the peripheral |
| per_rd_o | output | 1 | Word taken from the peripheral |
| per_rdata_i | input | 32 | Data from the peripheral |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The cycle-level assertions check the following on every cycle:
- the strobes of the two data directions never overlap;
- memory addresses stay word aligned;
- consecutive word moves step the address by exactly one word in the configured direction;
- each burst, slice or node starts only after a sampled request or with the bypass set;
- the port stays silent when idle;
- the done pulse coincides with the busy flag dropping.

Only the bench scenarios can show that the right number of words and slices move, that the chain follows its links and stops at the end marker, that data lands in the right memory words, and that register writes during a transfer leave no trace.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int REG_W = 32;

  localparam logic [1:0] RA_ADDR = 2'd0;
  localparam logic [1:0] RA_BLK  = 2'd1;
  localparam logic [1:0] RA_CTRL = 2'd2;

  localparam int CB_TO_PER = 0;
  localparam int CB_DOWN   = 1;
  localparam int CB_SLICE  = 9;
  localparam int CB_CHAIN  = 10;
  localparam int CB_BUSY   = 24;
  localparam int CB_NOREQ  = 28;

  localparam int CNT_W     = 16;
  localparam int HDR_CNT_W = 8;
  localparam int HDR_END   = 23;

  typedef struct packed {
    logic bypass;
    logic chain;
    logic slice;
    logic down;
    logic to_per;
  } ctrl_t;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_HDR, ST_MOVE} seq_st_e;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] cur_addr_i,
  output ctrl_t             ctrl_o,
  output logic [REG_W-1:0]  blk_o,
  output logic              start_o,
  output logic              base_we_o,
  output logic [REG_W-1:0]  rdata_o
);
  ctrl_t             ctrl_q;
  logic [REG_W-1:0]  blk_q;
  logic [REG_W-1:0]  ctrl_word;
  logic [REG_W-1:0]  addr_word;
  logic              wr_ok;

  assign wr_ok     = we_i && !busy_i;
  assign start_o   = wr_ok && (addr_i == RA_CTRL) && wdata_i[CB_BUSY];
  assign base_we_o = wr_ok && (addr_i == RA_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      blk_q  <= '0;
    end else if (wr_ok) begin
      if (addr_i == RA_BLK) blk_q <= wdata_i;
      if (addr_i == RA_CTRL) begin
        ctrl_q.to_per <= wdata_i[CB_TO_PER];
        ctrl_q.down   <= wdata_i[CB_DOWN];
        ctrl_q.slice  <= wdata_i[CB_SLICE];
        ctrl_q.chain  <= wdata_i[CB_CHAIN];
        ctrl_q.bypass <= wdata_i[CB_NOREQ];
      end
    end
  end

  always_comb begin
    ctrl_word            = '0;
    ctrl_word[CB_TO_PER] = ctrl_q.to_per;
    ctrl_word[CB_DOWN]   = ctrl_q.down;
    ctrl_word[CB_SLICE]  = ctrl_q.slice;
    ctrl_word[CB_CHAIN]  = ctrl_q.chain;
    ctrl_word[CB_NOREQ]  = ctrl_q.bypass;
    ctrl_word[CB_BUSY]   = busy_i;
  end

  generate
    if (ADDR_W < REG_W) begin : g_pad
      assign addr_word = {{(REG_W-ADDR_W){1'b0}}, cur_addr_i};
    end else begin : g_full
      assign addr_word = cur_addr_i;
    end
  endgenerate

  always_comb begin
    case (addr_i)
      RA_ADDR: rdata_o = addr_word;
      RA_BLK:  rdata_o = blk_q;
      RA_CTRL: rdata_o = ctrl_word;
      default: rdata_o = '0;
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign blk_o  = blk_q;
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:2] load_val_i,
  input  logic              step_i,
  input  logic              down_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int WA_W = ADDR_W - 2;

  logic [WA_W-1:0] wa_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     wa_q <= '0;
    else if (load_i) wa_q <= load_val_i;
    else if (step_i) wa_q <= down_i ? wa_q - WA_W'(1) : wa_q + WA_W'(1);
  end

  assign addr_o = {wa_q, 2'b00};
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  ctrl_t             ctrl_i,
  input  logic [REG_W-1:0]  blk_i,
  input  logic              per_req_i,
  input  logic [REG_W-1:2]  hdr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              move_o,
  output logic              hdr_o,
  output logic              step_o,
  output logic              down_o,
  output logic              load_o,
  output logic [ADDR_W-1:2] next_addr_o
);
  seq_st_e            st_q;
  logic [CNT_W-1:0]   words_q;
  logic [CNT_W-1:0]   slices_q;
  logic               end_q;
  logic [ADDR_W-1:2]  next_q;
  logic               done_q;

  logic [CNT_W-1:0]     blk_words, blk_slices;
  logic [HDR_CNT_W-1:0] hdr_cnt;
  logic                 hdr_end, hdr_empty;
  logic [ADDR_W-1:2]    hdr_next;
  logic                 go, last_word, no_work;

  assign blk_words  = blk_i[CNT_W-1:0];
  assign blk_slices = blk_i[2*CNT_W-1:CNT_W];
  assign hdr_cnt    = hdr_i[REG_W-1:REG_W-HDR_CNT_W];
  assign hdr_end    = hdr_i[HDR_END];
  assign hdr_empty  = (hdr_cnt == '0);
  assign hdr_next   = (ADDR_W-2)'(hdr_i[HDR_END:2]);

  assign go        = per_req_i || ctrl_i.bypass;
  assign last_word = (words_q == CNT_W'(1));
  // only true on the first wait: later slice waits always hold a reloaded count
  assign no_work   = !ctrl_i.chain &&
                     ((words_q == '0) || (ctrl_i.slice && slices_q == '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      words_q  <= '0;
      slices_q <= '0;
      end_q    <= 1'b0;
      next_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q     <= ST_WAIT;
          words_q  <= blk_words;
          slices_q <= blk_slices;
        end
        ST_WAIT: begin
          if (no_work) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else if (go) begin
            st_q <= ctrl_i.chain ? ST_HDR : ST_MOVE;
          end
        end
        ST_HDR: begin
          if (hdr_empty) begin
            st_q <= hdr_end ? ST_IDLE : ST_WAIT;
            done_q <= hdr_end;
          end else begin
            st_q    <= ST_MOVE;
            words_q <= CNT_W'(hdr_cnt);
            end_q   <= hdr_end;
            next_q  <= hdr_next;
          end
        end
        ST_MOVE: begin
          if (!last_word) begin
            words_q <= words_q - CNT_W'(1);
          end else if (ctrl_i.chain) begin
            st_q   <= end_q ? ST_IDLE : ST_WAIT;
            done_q <= end_q;
          end else if (ctrl_i.slice && slices_q != CNT_W'(1)) begin
            st_q     <= ST_WAIT;
            slices_q <= slices_q - CNT_W'(1);
            words_q  <= blk_words;
          end else begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = done_q;
  assign move_o      = (st_q == ST_MOVE);
  assign hdr_o       = (st_q == ST_HDR);
  assign step_o      = move_o || (hdr_o && !hdr_empty);
  assign down_o      = ctrl_i.down && !ctrl_i.chain;
  assign load_o      = (move_o && last_word && ctrl_i.chain && !end_q) ||
                       (hdr_o && hdr_empty && !hdr_end);
  assign next_addr_o = hdr_o ? hdr_next : next_q;
endmodule

// File: rtl/dma_channel.sv
module dma_channel
  import dma_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       mem_rdata_i,
  input  logic              per_req_i,
  output logic              per_wr_o,
  output logic [31:0]       per_wdata_o,
  output logic              per_rd_o,
  input  logic [31:0]       per_rdata_i,
  output logic              done_o
);
  ctrl_t              ctrl;
  logic [REG_W-1:0]   blk;
  logic               start, base_we, busy, move, hdr, step, down, seq_load;
  logic [ADDR_W-1:2]  next_addr;
  logic [ADDR_W-1:0]  cur_addr;
  logic               to_per, byp_w;

  dma_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .busy_i     (busy),
    .cur_addr_i (cur_addr),
    .ctrl_o     (ctrl),
    .blk_o      (blk),
    .start_o    (start),
    .base_we_o  (base_we),
    .rdata_o    (reg_rdata_o)
  );

  dma_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i, .rst_ni,
    .start_i     (start),
    .ctrl_i      (ctrl),
    .blk_i       (blk),
    .per_req_i   (per_req_i),
    .hdr_i       (mem_rdata_i[31:2]),
    .busy_o      (busy),
    .done_o      (done_o),
    .move_o      (move),
    .hdr_o       (hdr),
    .step_o      (step),
    .down_o      (down),
    .load_o      (seq_load),
    .next_addr_o (next_addr)
  );

  dma_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i, .rst_ni,
    .load_i     (base_we || seq_load),
    .load_val_i (base_we ? reg_wdata_i[ADDR_W-1:2] : next_addr),
    .step_i     (step),
    .down_i     (down),
    .addr_o     (cur_addr)
  );

  // chain payloads always flow toward the peripheral
  assign to_per      = ctrl.to_per || ctrl.chain;
  assign byp_w       = ctrl.bypass;

  assign mem_req_o   = move || hdr;
  assign mem_we_o    = move && !to_per;
  assign mem_addr_o  = cur_addr;
  assign mem_wdata_o = per_rdata_i;
  assign per_wr_o    = move && to_per;
  assign per_wdata_o = mem_rdata_i;
  assign per_rd_o    = move && !to_per;
endmodule

// File: rtl/dma_channel_chk.sv
module dma_channel_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_req_i,
  input logic              mem_we_i,
  input logic [ADDR_W-1:0] mem_addr_i,
  input logic              per_wr_i,
  input logic              per_rd_i,
  input logic              per_req_i,
  input logic              done_i,
  input logic              busy_i,
  input logic              move_i,
  input logic              bypass_i,
  input logic              down_i
);
  AST_DIR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(per_wr_i && per_rd_i)); // R2
  AST_WR_FROM_PER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |-> (per_rd_i && mem_req_i)); // R3
  AST_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i |-> (mem_addr_i[1:0] == 2'b00)); // R4
  AST_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (move_i && $past(move_i)) |->
      (mem_addr_i == (down_i ? $past(mem_addr_i) - ADDR_W'(4)
                             : $past(mem_addr_i) + ADDR_W'(4)))); // R4
  AST_REQ_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_i) |-> ($past(per_req_i) || bypass_i)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !(mem_req_i || per_wr_i || per_rd_i)); // R10
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> !busy_i); // R10
  AST_DONE_ON_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> done_i); // R10
endmodule

bind dma_channel dma_channel_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mem_req_i  (mem_req_o),
  .mem_we_i   (mem_we_o),
  .mem_addr_i (mem_addr_o),
  .per_wr_i   (per_wr_o),
  .per_rd_i   (per_rd_o),
  .per_req_i  (per_req_i),
  .done_i     (done_o),
  .busy_i     (busy),
  .move_i     (move),
  .bypass_i   (byp_w),
  .down_i     (down)
);

// File: tb/tb_dma_channel.sv
`timescale 1ns/1ps
module tb_dma_channel;
  localparam logic [31:0] C_TO   = 32'h1 << 0;
  localparam logic [31:0] C_DN   = 32'h1 << 1;
  localparam logic [31:0] C_SL   = 32'h1 << 9;
  localparam logic [31:0] C_CH   = 32'h1 << 10;
  localparam logic [31:0] C_GO   = 32'h1 << 24;
  localparam logic [31:0] C_BYP  = 32'h1 << 28;
  localparam logic [31:0] PBASE  = 32'hC0DE_0000;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [1:0] reg_addr = 2'd2;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic mem_req, mem_we, per_wr, per_rd, done, per_req = 0;
  logic [23:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata, per_wdata, per_rdata;

  logic [31:0] mem [0:1023];
  int per_cnt = 0, n_moves = 0, n_pwr = 0;
  logic [31:0] pwr_q[$];
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  dma_channel dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .per_req_i(per_req), .per_wr_o(per_wr), .per_wdata_o(per_wdata),
    .per_rd_o(per_rd), .per_rdata_i(per_rdata), .done_o(done)
  );

  assign mem_rdata = mem[mem_addr[11:2]];
  assign per_rdata = PBASE + per_cnt;

  always @(posedge clk) begin
    if (mem_req && mem_we) mem[mem_addr[11:2]] <= mem_wdata;
    if (per_rd) per_cnt <= per_cnt + 1;
    if (per_wr || per_rd) n_moves <= n_moves + 1;
    if (per_wr) begin n_pwr <= n_pwr + 1; pwr_q.push_back(per_wdata); end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // behavioural reference: 0 idle, 1 wait, 2 move, 3 header
  int m_st = 0, m_words = 0, m_slices = 0, m_pcnt = 0;
  logic [23:0] m_addr = 0, m_next = 0;
  logic [31:0] m_blk = 0, h;
  bit m_end = 0, m_busy = 0, m_done = 0;
  bit c_to = 0, c_dn = 0, c_sl = 0, c_ch = 0, c_by = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_addr = 0; m_blk = 0; m_busy = 0; m_done = 0; m_pcnt = 0;
      c_to = 0; c_dn = 0; c_sl = 0; c_ch = 0; c_by = 0;
    end else begin
      m_done = 0;
      case (m_st)
        0: if (reg_we) begin
          if (reg_addr == 0) m_addr = reg_wdata[23:0] & 24'hFFFFFC;
          else if (reg_addr == 1) m_blk = reg_wdata;
          else if (reg_addr == 2) begin
            c_to = reg_wdata[0]; c_dn = reg_wdata[1]; c_sl = reg_wdata[9];
            c_ch = reg_wdata[10]; c_by = reg_wdata[28];
            if (reg_wdata[24]) begin
              m_busy = 1; m_st = 1; m_words = m_blk[15:0]; m_slices = m_blk[31:16];
            end
          end
        end
        1: begin
          if (!c_ch && (m_words == 0 || (c_sl && m_slices == 0))) begin
            m_st = 0; m_busy = 0; m_done = 1;
          end else if (per_req || c_by) m_st = c_ch ? 3 : 2;
        end
        3: begin
          h = mem[m_addr[11:2]];
          if (h[31:24] == 0) begin
            if (h[23]) begin m_st = 0; m_busy = 0; m_done = 1; end
            else begin m_addr = h[23:0] & 24'hFFFFFC; m_st = 1; end
          end else begin
            m_addr = m_addr + 4; m_words = h[31:24]; m_end = h[23];
            m_next = h[23:0] & 24'hFFFFFC; m_st = 2;
          end
        end
        default: begin
          if (!(c_to || c_ch)) m_pcnt++;
          m_addr = (c_dn && !c_ch) ? m_addr - 4 : m_addr + 4;
          if (m_words > 1) m_words--;
          else if (c_ch) begin
            if (m_end) begin m_st = 0; m_busy = 0; m_done = 1; end
            else begin m_addr = m_next; m_st = 1; end
          end else if (c_sl && m_slices > 1) begin
            m_slices--; m_words = m_blk[15:0]; m_st = 1;
          end else begin m_st = 0; m_busy = 0; m_done = 1; end
        end
      endcase
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      bit to, mv;
      to = c_to || c_ch;
      mv = (m_st == 2);
      check(mem_req == (mv || m_st == 3), "R5 mem_req_o", {31'b0, mem_req}, {31'b0, mv || m_st == 3});
      if (mv || m_st == 3) check(mem_addr == m_addr, "R4 mem_addr_o", {8'b0, mem_addr}, {8'b0, m_addr});
      check(per_wr == (mv && to), "R2 per_wr_o", {31'b0, per_wr}, {31'b0, mv && to});
      check(per_rd == (mv && !to), "R3 per_rd_o", {31'b0, per_rd}, {31'b0, mv && !to});
      check(mem_we == (mv && !to), "R3 mem_we_o", {31'b0, mem_we}, {31'b0, mv && !to});
      if (mv && to) check(per_wdata == mem[m_addr[11:2]], "R2 per_wdata_o", per_wdata, mem[m_addr[11:2]]);
      if (mv && !to) check(mem_wdata == PBASE + m_pcnt, "R3 mem_wdata_o", mem_wdata, PBASE + m_pcnt);
      check(done == m_done, "R10 done_o", {31'b0, done}, {31'b0, m_done});
      if (!reg_we && reg_addr == 2)
        check(reg_rdata[24] == m_busy, "R10 busy readback", {31'b0, reg_rdata[24]}, {31'b0, m_busy});
    end
  end

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0; reg_addr = 2;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #2 d = reg_rdata; reg_addr = 2;
  endtask

  task automatic run_to_done(input bit pace, input string tag);
    bit seen = 0;
    for (int i = 0; i < 400 && !seen; i++) begin
      @(negedge clk);
      if (pace) per_req = (i % 5 == 0);
      if (done) seen = 1;
    end
    per_req = 0;
    check(seen, tag, {31'b0, seen}, 32'h1);
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int p0, n0;
    for (int i = 0; i < 1024; i++) mem[i] = 32'h5000_0000 + i;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    for (int a = 0; a < 3; a++) begin
      reg_read(a[1:0], d);
      check(d == 0, "R1 reset register", d, 0);
    end
    check(!done && !mem_req && !per_wr && !per_rd, "R1 idle ports", {28'b0, done, mem_req, per_wr, per_rd}, 0);

    // R2/R4/R5 burst to peripheral, upward, masked base
    reg_write(0, 32'h43);
    reg_read(0, d);
    check(d == 32'h40, "R4 base low bits ignored", d, 32'h40);
    reg_write(1, 4);
    n0 = n_pwr;
    reg_write(2, C_TO | C_GO | C_BYP);
    run_to_done(0, "R5 burst completes");
    check(n_pwr - n0 == 4, "R5 burst word count", n_pwr - n0, 4);
    reg_read(0, d);
    check(d == 32'h50, "R4 final address up", d, 32'h50);

    // R3/R7 burst from peripheral, downward, request paced
    reg_write(0, 32'h100);
    reg_write(1, 3);
    p0 = per_cnt;
    reg_write(2, C_DN | C_GO);
    n0 = n_moves;
    repeat (6) @(negedge clk);
    check(n_moves == n0, "R7 no move without request", n_moves - n0, 0);
    per_req = 1;
    run_to_done(0, "R3 burst completes");
    check(mem[32'h100 >> 2] == PBASE + p0,     "R3 mem word 0", mem[32'h100 >> 2], PBASE + p0);
    check(mem[32'hFC >> 2]  == PBASE + p0 + 1, "R3 mem word 1", mem[32'hFC >> 2], PBASE + p0 + 1);
    check(mem[32'hF8 >> 2]  == PBASE + p0 + 2, "R3 mem word 2", mem[32'hF8 >> 2], PBASE + p0 + 2);
    reg_read(0, d);
    check(d == 32'hF4, "R4 final address down", d, 32'hF4);

    // R6/R11 paced slices with writes while busy
    reg_write(0, 32'h200);
    reg_write(1, 32'h0003_0002);
    n0 = n_pwr;
    reg_write(2, C_SL | C_TO | C_GO);
    reg_write(1, 32'hFFFF_FFFF);
    reg_write(0, 32'h3F0);
    reg_write(2, C_GO | C_BYP | C_TO);
    run_to_done(1, "R6 slices complete");
    check(n_pwr - n0 == 6, "R6 slice word total", n_pwr - n0, 6);
    reg_read(1, d);
    check(d == 32'h0003_0002, "R11 block write ignored", d, 32'h0003_0002);
    reg_read(0, d);
    check(d == 32'h218, "R11 address write ignored", d, 32'h218);
    reg_read(2, d);
    check(d[28] == 0 && d[9] == 1, "R11 control write ignored", d, C_SL | C_TO);

    // R8/R9 chain: node with 2 words, empty node, final node with 1 word
    mem[32'h300 >> 2] = {8'd2, 24'h000340};
    mem[32'h340 >> 2] = {8'd0, 24'h000380};
    mem[32'h380 >> 2] = {8'd1, 24'h800000};
    reg_write(0, 32'h300);
    pwr_q.delete();
    reg_write(2, C_CH | C_DN | C_GO | C_BYP);
    run_to_done(0, "R8 chain completes");
    check(pwr_q.size() == 3, "R9 chain word total", pwr_q.size(), 3);
    if (pwr_q.size() == 3) begin
      check(pwr_q[0] == 32'h5000_00C1, "R8 chain word 0", pwr_q[0], 32'h5000_00C1);
      check(pwr_q[1] == 32'h5000_00C2, "R8 chain word 1", pwr_q[1], 32'h5000_00C2);
      check(pwr_q[2] == 32'h5000_00E1, "R8 chain word 2", pwr_q[2], 32'h5000_00E1);
    end
    reg_read(0, d);
    check(d == 32'h388, "R9 chain stops at end marker", d, 32'h388);

    // R12 zero length
    reg_write(1, 0);
    n0 = n_moves;
    reg_write(2, C_TO | C_GO | C_BYP);
    run_to_done(0, "R12 zero length done");
    check(n_moves == n0, "R12 zero length moves", n_moves - n0, 0);
    reg_write(1, 32'h0000_0005);
    reg_write(2, C_SL | C_GO | C_BYP);
    run_to_done(0, "R12 zero slices done");
    check(n_moves == n0, "R12 zero slices moves", n_moves - n0, 0);

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule